// File: doc/BRIEF.md
# Phase to sine/cosine generator

This block turns a stream of phase words into complex sinusoid samples of unit magnitude, cos(2πx) + j·sin(2πx). The phase word is an unsigned fraction of a full turn. The result is a pair of signed fixed-point values with 14 fractional bits. The block uses a lookup table that holds a quarter of a wave. The full circle comes from quadrant folding and sign restoration. It suits a mixer or tuner that needs a local oscillator in cartesian form, fed from a phase accumulator upstream.

Both sides of the block are valid/ready streams. A word moves when valid and ready are high on the same rising edge. The pipeline moves as one unit. While the output holds a sample the consumer has not taken, every stage freezes and the input refuses new words. A sample that is presented stays unchanged until it is taken. An end-of-packet flag travels beside each word and comes out with its own sample. Reset is synchronous and active low. It should be held low for at least two clock cycles. The block also keeps its input closed for one further cycle after release.

Top module: `sincos_gen`

## Requirements
- R1: Only the top 12 bits of the 24-bit phase word, n = in_phase[23:12], set the angle 2π·n/4096. The low 12 bits have no effect on the output.
- R2: out_data[31:16] carries sine and out_data[15:0] carries cosine, each two's complement with 14 fractional bits, within ±1 code of round(16383·sin(2πn/4096)) and round(16383·cos(2πn/4096)).
- R3: Quadrant points are exact. n=0 gives cos=16383 and sin=0. n=1024 gives sin=16383 and cos=0. n=2048 gives cos=-16383 and sin=0. n=3072 gives sin=-16383 and cos=0.
- R4: No output value lies outside the range -16383 to +16383.
- R5: With out_ready held high, a word accepted on one edge is presented on out_valid after the second rising edge that follows. The output is therefore first visible three sampling points after the input is driven. One word can be accepted per cycle.
- R6: out_last equals the in_last that was accepted with the matching phase word, and samples leave in acceptance order.
- R7: While out_valid is high and out_ready is low, the next cycle shows out_valid still high with out_data and out_last unchanged.
- R8: Outside reset, in_ready is high exactly when out_valid is low or out_ready is high.
- R9: While rst_n is low, and for one cycle after it rises, in_ready and out_valid are low. The pipeline holds no words afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Phase word present |
| in_ready | output | 1 | Block accepts a phase word this cycle |
| in_phase | input | 24 | Unsigned phase, fraction of a full turn |
| in_last | input | 1 | End-of-packet flag for the phase word |
| out_valid | output | 1 | Sample present |
| out_ready | input | 1 | Consumer takes the sample this cycle |
| out_data | output | 32 | {sine, cosine}, each signed with 14 fractional bits |
| out_last | output | 1 | End-of-packet flag for the sample |

## Verification
The assertions assume that rst_n is synchronous to clk and is driven low at time zero. They also assume the consumer changes out_ready only between edges. They do not constrain in_valid, in_phase or in_last, because the block itself never holds a word that it has refused. The bench holds reset low for three cycles and drives every input half a period away from the rising edge. It keeps a presented phase word and its flag steady until they are accepted, so the reference queue matches the order the block sees.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  typedef enum logic [1:0] {
    QD_0 = 2'd0,
    QD_1 = 2'd1,
    QD_2 = 2'd2,
    QD_3 = 2'd3
  } quad_e;

  // Rounded magnitude of sin(pi/2 * k / q_len) scaled by amp.
  function automatic int quarter_mag(input int k, input int q_len, input int amp);
    real ang;
    ang = 1.5707963267948966 * real'(k) / real'(q_len);
    return $rtoi(real'(amp) * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/sincos_fold.sv
module sincos_fold
  import sincos_pkg::*;
#(
  parameter int IDX_W = 12,
  localparam int Q_W  = IDX_W - 2
) (
  input  logic [IDX_W-1:0] idx,
  output quad_e            quad,
  output logic [Q_W-1:0]   addr_s,
  output logic [Q_W-1:0]   addr_c,
  output logic             c_full
);

  always_comb begin
    quad   = quad_e'(idx[IDX_W-1 -: 2]);
    addr_s = idx[Q_W-1:0];
    // mirrored address inside the quadrant; zero offset means full scale
    addr_c = Q_W'(0) - addr_s;
    c_full = (addr_s == '0);
  end

endmodule

// File: rtl/sincos_quarter_rom.sv
module sincos_quarter_rom #(
  parameter int Q_W   = 10,
  parameter int MAG_W = 14,
  parameter int AMP   = 16383,
  localparam int DEPTH = 1 << Q_W
) (
  input  logic             clk,
  input  logic             en,
  input  logic [Q_W-1:0]   addr_a,
  input  logic [Q_W-1:0]   addr_b,
  output logic [MAG_W-1:0] rd_a,
  output logic [MAG_W-1:0] rd_b
);

  logic [MAG_W-1:0] tbl [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      tbl[k] = MAG_W'(sincos_pkg::quarter_mag(k, DEPTH, AMP));
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      rd_a <= tbl[addr_a];
      rd_b <= tbl[addr_b];
    end
  end

endmodule

// File: rtl/sincos_unfold.sv
module sincos_unfold
  import sincos_pkg::*;
#(
  parameter int MAG_W = 14,
  parameter int OUT_W = 16
) (
  input  quad_e                    quad,
  input  logic [MAG_W-1:0]         mag_s,
  input  logic [MAG_W-1:0]         mag_c,
  output logic signed [OUT_W-1:0]  sin_v,
  output logic signed [OUT_W-1:0]  cos_v
);

  logic signed [OUT_W-1:0] ps;
  logic signed [OUT_W-1:0] pc;

  always_comb begin
    ps = signed'({{(OUT_W-MAG_W){1'b0}}, mag_s});
    pc = signed'({{(OUT_W-MAG_W){1'b0}}, mag_c});
    unique case (quad)
      QD_0: begin sin_v =  ps; cos_v =  pc; end
      QD_1: begin sin_v =  pc; cos_v = -ps; end
      QD_2: begin sin_v = -ps; cos_v = -pc; end
      default: begin sin_v = -pc; cos_v =  ps; end
    endcase
  end

endmodule

// File: rtl/sincos_gen.sv
module sincos_gen
  import sincos_pkg::*;
#(
  parameter int PH_W  = 24,
  parameter int IDX_W = 12,
  parameter int OUT_W = 16,
  parameter int FRAC  = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PH_W-1:0]      in_phase,
  input  logic                 in_last,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*OUT_W-1:0]   out_data,
  output logic                 out_last
);

  localparam int Q_W   = IDX_W - 2;
  localparam int MAG_W = FRAC;
  localparam int AMP   = (1 << FRAC) - 1;
  localparam int DROP  = PH_W - IDX_W;

  // reset stretch: clear while reset is low and one cycle after
  logic rst_hold;
  logic clr;
  always_ff @(posedge clk) rst_hold <= ~rst_n;
  assign clr = ~rst_n | rst_hold;

  logic v1, v2, v3;
  logic en;
  assign en       = ~v3 | out_ready;
  assign in_ready = en & ~clr;

  logic unused_phase_lsbs;
  assign unused_phase_lsbs = ^in_phase[DROP-1:0];

  // stage 1: quadrant fold
  quad_e           f_quad;
  logic [Q_W-1:0]  f_as, f_ac;
  logic            f_cf;

  sincos_fold #(.IDX_W(IDX_W)) u_fold (
    .idx    (in_phase[PH_W-1 -: IDX_W]),
    .quad   (f_quad),
    .addr_s (f_as),
    .addr_c (f_ac),
    .c_full (f_cf)
  );

  quad_e           quad1, quad2;
  logic [Q_W-1:0]  as1, ac1;
  logic            cf1, cf2;
  logic            last1, last2, last3;

  always_ff @(posedge clk) begin
    if (en) begin
      quad1 <= f_quad;
      as1   <= f_as;
      ac1   <= f_ac;
      cf1   <= f_cf;
      last1 <= in_last;
    end
  end

  // stage 2: table read
  logic [MAG_W-1:0] rd_s, rd_c;

  sincos_quarter_rom #(.Q_W(Q_W), .MAG_W(MAG_W), .AMP(AMP)) u_rom (
    .clk    (clk),
    .en     (en),
    .addr_a (as1),
    .addr_b (ac1),
    .rd_a   (rd_s),
    .rd_b   (rd_c)
  );

  always_ff @(posedge clk) begin
    if (en) begin
      quad2 <= quad1;
      cf2   <= cf1;
      last2 <= last1;
    end
  end

  // stage 3: sign restore and output register
  logic [MAG_W-1:0]        mag_c;
  logic signed [OUT_W-1:0] u_sin, u_cos;
  logic signed [OUT_W-1:0] sin3, cos3;

  assign mag_c = cf2 ? {MAG_W{1'b1}} : rd_c;

  sincos_unfold #(.MAG_W(MAG_W), .OUT_W(OUT_W)) u_unfold (
    .quad  (quad2),
    .mag_s (rd_s),
    .mag_c (mag_c),
    .sin_v (u_sin),
    .cos_v (u_cos)
  );

  always_ff @(posedge clk) begin
    if (en) begin
      sin3  <= u_sin;
      cos3  <= u_cos;
      last3 <= last2;
    end
  end

  // valid chain
  always_ff @(posedge clk) begin
    if (clr) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (en) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  assign out_valid = v3;
  assign out_data  = {sin3, cos3};
  assign out_last  = last3;

endmodule

// File: rtl/sincos_gen_chk.sv
module sincos_gen_chk #(
  parameter int OUT_W = 16,
  parameter int FRAC  = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [2*OUT_W-1:0] out_data,
  input logic               out_last
);

  localparam logic signed [OUT_W-1:0] AMP_S = OUT_W'((1 << FRAC) - 1);

  logic prev_rst_n;
  always_ff @(posedge clk) prev_rst_n <= rst_n;

  logic signed [OUT_W-1:0] c_sin, c_cos;
  assign c_sin = out_data[2*OUT_W-1:OUT_W];
  assign c_cos = out_data[OUT_W-1:0];

  // R4
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (c_sin <= AMP_S) && (c_sin >= -AMP_S) && (c_cos <= AMP_S) && (c_cos >= -AMP_S));

  // R7
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R8
  a_r8_block_when_full: assert property (@(posedge clk) disable iff (!rst_n || !prev_rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  a_r8_open_when_empty: assert property (@(posedge clk) disable iff (!rst_n || !prev_rst_n)
    !out_valid |-> in_ready);

  // R9
  a_r9_release_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_rst_n |-> (!in_ready && !out_valid));

endmodule

bind sincos_gen sincos_gen_chk #(.OUT_W(OUT_W), .FRAC(FRAC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/sincos_gen_tb.sv
module sincos_gen_tb;

  localparam int CLK_P = 10;
  localparam int NSAMP = 3000;
  localparam real TWO_PI = 6.283185307179586;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [23:0] in_phase;
  logic        in_last;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        out_last;

  always #(CLK_P/2) clk = ~clk;

  sincos_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_phase(in_phase), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_val(input int n, input bit is_sin);
    real ang, v;
    ang = TWO_PI * real'(n) / 4096.0;
    v = 16383.0 * (is_sin ? $sin(ang) : $cos(ang));
    if (v >= 0.0) return $rtoi(v + 0.5);
    else return -$rtoi(-v + 0.5);
  endfunction

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  logic [24:0] q [0:4095];
  int wr = 0;
  int rd = 0;

  task automatic compare(input logic [24:0] e);
    logic signed [15:0] gs, gc;
    int n, es, ec;
    string rq;
    gs = out_data[31:16];
    gc = out_data[15:0];
    n  = int'(e[23:12]);
    es = ref_val(n, 1'b1);
    ec = ref_val(n, 1'b0);
    rq = (e[11:0] != 12'd0) ? "R1" : "R2";
    chk(iabs(int'(gs) - es) <= 1, {rq, " sine"}, int'(gs), es);
    chk(iabs(int'(gc) - ec) <= 1, {rq, " cosine"}, int'(gc), ec);
    chk(iabs(int'(gs)) <= 16383 && iabs(int'(gc)) <= 16383, "R4 range", iabs(int'(gs)) + iabs(int'(gc)), 16383);
    chk(out_last == e[24], "R6 last", int'(out_last), int'(e[24]));
    if (n[9:0] == 10'd0) begin
      chk(int'(gs) == es && int'(gc) == ec, "R3 quadrant point", {16'd0, gs} * 65536 + int'(gc), es * 65536 + ec);
    end
  endtask

  function automatic logic [23:0] pick_phase(input int i);
    case (i)
      0: return 24'h000000;
      1: return 24'h400000;
      2: return 24'h800000;
      3: return 24'hC00000;
      4: return 24'h000FFF;
      5: return 24'hFFFFFF;
      6: return 24'h3FF000;
      7: return 24'h401ABC;
      default: return 24'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", rd, NSAMP);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    int sent;
    bit pend;
    bit hold_prev;
    logic [31:0] hold_data;
    logic hold_last;
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; in_phase = '0; in_last = 1'b0; out_ready = 1'b0;

    // R9 during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!in_ready && !out_valid, "R9 in reset", int'(in_ready) + int'(out_valid), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!in_ready && !out_valid, "R9 release cycle", int'(in_ready), 0);
    @(negedge clk); #1;
    chk(in_ready && !out_valid, "R9 open after release", int'(in_ready), 1);

    // R5 latency with a single word
    @(negedge clk);
    in_valid = 1'b1; in_phase = 24'h400000; in_last = 1'b1; out_ready = 1'b1;
    #1;
    chk(in_ready, "R8 ready while empty", int'(in_ready), 1);
    cnt = 0;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      #1;
      if (out_valid && cnt == 0) cnt = i;
      if (cnt != 0) break;
      @(negedge clk);
    end
    chk(cnt == 3, "R5 latency", cnt, 3);
    chk(out_data == {16'sd16383, 16'sd0}, "R3 quarter turn", int'(out_data), 16383 * 65536);
    chk(out_last, "R6 last single", int'(out_last), 1);
    @(negedge clk); #1;
    chk(!out_valid, "R5 single sample drained", int'(out_valid), 0);

    // streaming with random back-pressure
    sent = 0; pend = 0; hold_prev = 0; hold_data = '0; hold_last = 1'b0;
    while (rd < NSAMP) begin
      @(negedge clk);
      if (!pend) begin
        if (sent < NSAMP && ($urandom % 10) < 7) begin
          in_phase = pick_phase(sent);
          in_last  = (($urandom % 8) == 0);
          in_valid = 1'b1;
          pend = 1;
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = (($urandom % 10) < 6);
      #1;
      if (hold_prev) begin
        chk(out_valid && out_data == hold_data && out_last == hold_last, "R7 hold",
            int'(out_data), int'(hold_data));
      end
      hold_prev = out_valid && !out_ready;
      hold_data = out_data;
      hold_last = out_last;
      chk(in_ready == (!out_valid || out_ready), "R8 ready rule", int'(in_ready),
          int'(!out_valid || out_ready));
      if (in_valid && in_ready) begin
        q[wr % 4096] = {in_last, in_phase};
        wr++; sent++; pend = 0;
      end
      if (out_valid && out_ready) begin
        if (rd >= wr) chk(1'b0, "R6 order", rd, wr);
        else compare(q[rd % 4096]);
        rd++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk(rd == wr, "R6 count", rd, wr);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule